// File: doc/BRIEF.md
# Cheat Cartridge Patch Controller

This block sits on a 16-bit processor bus in front of a game cartridge. Before it is armed, it serves the lowest 64 KB of the address space from its own 32 KB program ROM, which appears twice in that window. Software running from that ROM writes up to four patch entries into a small write-only register file. Each entry holds a replacement data word and a word address that is split across two registers. A final key write arms the block. Arming latches all four entries, locks the register file and hands the low window back to the cartridge.

Once armed, each entry falls into one of three classes. An entry pointing into cartridge ROM space replaces that ROM word on every read. An entry pointing into work RAM space is written into RAM once, through a valid/ready write port. An entry pointing anywhere else does nothing. Reads are substituted combinationally. If several ROM entries hit the same word, the lowest-numbered entry wins. A synchronous reset drops every patch, so reads return the original cartridge contents, and brings back the boot ROM mapping.

Top module: `cheat_patch_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy` and `ramValid` are 0, `unusedWr` is 0 when no write is presented, and reads in the low window come from the boot ROM.
- R2: A write with byte address 0x010000 to 0x010018 goes into register index `busAddr[4:1]` (0 to 12) and leaves `unusedWr` at 0. A write to any other address is dropped and raises `unusedWr` in the same cycle.
- R3: Writing 0xFFFF to index 3 arms the block. Writing any other value to index 3 does not arm it. Once armed, every write is dropped and raises `unusedWr`.
- R4: Entry k (k = 0 to 3) takes its data from index 0, 4, 7, 10, its low address word from index 1, 5, 8, 11 and its high word from index 2, 6, 9, 12. The byte address of the entry is ((low | ((high & 0x7F00) << 8)) << 1).
- R5: While unarmed, a read whose byte address bits [23:16] are 0 drives `bootAddr` with byte address bits [14:1] and returns `bootData`, so byte offsets 0x8000 to 0xFFFF repeat 0x0000 to 0x7FFF. All other reads return `cartData`.
- R6: While armed, a read in the low window that hits no ROM entry returns `cartData`.
- R7: While armed, a read whose word address equals that of an entry with address bits [23:16] below 0x40 returns that entry's data. The lowest-numbered matching entry wins.
- R8: On arming, every entry with address bits [23:16] at 0xE0 or above is presented on the RAM port in entry order, one entry per accepted handshake. `ramAddr` is the entry's low 16 byte-address bits. Valid, address and data hold while `ramReady` is low. `busy` stays high until the last entry is accepted.
- R9: An entry with address bits [23:16] from 0x40 to 0xDF neither substitutes reads nor produces a RAM write.
- R10: Reset clears every register. Arming right after reset therefore yields four ROM entries at address 0 with data 0, and no earlier patch remains visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busWe | input | 1 | Bus write strobe |
| busAddr | input | 24 | Bus write byte address |
| busWdata | input | 16 | Bus write data |
| unusedWr | output | 1 | Presented write was dropped (open-bus write path) |
| rdWord | input | 23 | Read word address (byte address bits [23:1]) |
| bootAddr | output | 14 | Word address into the internal boot ROM |
| bootData | input | 16 | Boot ROM read data |
| cartData | input | 16 | Cartridge ROM read data for `rdWord` |
| rdData | output | 16 | Read data returned to the processor |
| ramValid | output | 1 | RAM patch write request valid |
| ramReady | input | 1 | RAM accepts the request |
| ramAddr | output | 16 | RAM byte address of the patch write |
| ramData | output | 16 | RAM patch write data |
| busy | output | 1 | RAM patch writes still pending |

## Verification
A wrong entry decode shows up at once as a wrong read word, or as a wrong address or order on the RAM port. The bench sweeps every word of the low 16 KB and the boundary words of the patched regions after arming, and compares each read against the entries it rebuilt from the raw register values. A lock flag that is wrong shows up in the same cycle, either through `unusedWr` on a write or through the source the low window reads from. A RAM sequencer that is wrong shows up within a few cycles of arming as a missing, repeated, reordered or unstable request while the bench stalls `ramReady`.

// File: rtl/cheat_patch_pkg.sv
package cheat_patch_pkg;
  localparam int NUM_SLOTS  = 4;
  localparam int NUM_REGS   = 13;
  localparam int KEY_IDX    = 3;
  localparam logic [15:0] ARM_KEY = 16'hFFFF;

  // strobes from control to datapath
  typedef struct packed {
    logic       regWe;
    logic [3:0] regIdx;
    logic       commit;
    logic       locked;
    logic [1:0] ramSel;
  } patch_strobe_t;

  // register index of slot k data word; low and high words follow it
  function automatic int slotDataIdx(input int k);
    return (k == 0) ? 0 : 3 * k + 1;
  endfunction
endpackage

// File: rtl/cheat_patch_ctrl_fsm.sv
module cheat_patch_ctrl_fsm
  import cheat_patch_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] REG_BASE = 24'h010000,
  parameter logic [ADDR_W-1:0] REG_LAST = 24'h010018
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 busWe,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic [NUM_SLOTS-1:0] ramMaskNext,
  input  logic                 ramReady,
  output patch_strobe_t        strobes,
  output logic                 unusedWr,
  output logic                 ramValid,
  output logic                 busy
);
  logic                 locked;
  logic [NUM_SLOTS-1:0] pending;
  logic                 inRange;
  logic                 regWe;
  logic                 commit;
  logic [1:0]           ramSel;

  assign inRange  = (busAddr >= REG_BASE) && (busAddr <= REG_LAST);
  assign regWe    = busWe && inRange && !locked;
  assign commit   = regWe && (busAddr[4:1] == 4'(KEY_IDX)) && (busWdata == ARM_KEY);
  assign unusedWr = busWe && !regWe;

  // lowest pending slot goes first
  always_comb begin
    ramSel = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (pending[s]) ramSel = 2'(s);
    end
  end

  assign ramValid = |pending;
  assign busy     = ramValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked  <= 1'b0;
      pending <= '0;
    end else if (commit) begin
      locked  <= 1'b1;
      pending <= ramMaskNext;
    end else if (ramValid && ramReady) begin
      pending[ramSel] <= 1'b0;
    end
  end

  always_comb begin
    strobes.regWe  = regWe;
    strobes.regIdx = busAddr[4:1];
    strobes.commit = commit;
    strobes.locked = locked;
    strobes.ramSel = ramSel;
  end

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);
  // R3
  locked_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && busWe) |-> unusedWr);
  // R8
  ram_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ramValid && !ramReady) |=> (ramValid && $stable(ramSel)));
  // R8
  ram_armed_chk: assert property (@(posedge clk) disable iff (rst)
    ramValid |-> locked);
  // R8
  pending_shrink_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && !commit) |=> ($countones(pending) <= $countones($past(pending))));
endmodule

// File: rtl/cheat_patch_datapath.sv
module cheat_patch_datapath
  import cheat_patch_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int BOOT_AW = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  patch_strobe_t        strobes,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic [ADDR_W-2:0]    rdWord,
  output logic [BOOT_AW-1:0]   bootAddr,
  input  logic [DATA_W-1:0]    bootData,
  input  logic [DATA_W-1:0]    cartData,
  output logic [DATA_W-1:0]    rdData,
  output logic [15:0]          ramAddr,
  output logic [DATA_W-1:0]    ramData,
  output logic [NUM_SLOTS-1:0] ramMaskNext
);
  localparam int WORD_W = ADDR_W - 1;
  localparam int PAGE_W = 8;

  logic [DATA_W-1:0] regFile [NUM_REGS];

  logic [NUM_SLOTS-1:0][DATA_W-1:0] slotData;
  logic [NUM_SLOTS-1:0][WORD_W-1:0] slotWord;
  logic [NUM_SLOTS-1:0]             slotRom;

  logic [NUM_SLOTS-1:0][WORD_W-1:0] candWord;
  logic [NUM_SLOTS-1:0]             candRom;
  logic                             inWindow;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else if (strobes.regWe) begin
      regFile[strobes.regIdx] <= busWdata;
    end
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam int DI = slotDataIdx(k);
    logic [PAGE_W-1:0] page;
    assign candWord[k]    = {regFile[DI+2][14:8], regFile[DI+1]};
    assign page           = candWord[k][WORD_W-1 -: PAGE_W];
    assign candRom[k]     = page < 8'h40;
    assign ramMaskNext[k] = page >= 8'hE0;

    always_ff @(posedge clk) begin
      if (rst) begin
        slotData[k] <= '0;
        slotWord[k] <= '0;
        slotRom[k]  <= 1'b0;
      end else if (strobes.commit) begin
        slotData[k] <= regFile[DI];
        slotWord[k] <= candWord[k];
        slotRom[k]  <= candRom[k];
      end
    end
  end

  assign bootAddr = rdWord[BOOT_AW-1:0];
  assign inWindow = (rdWord[WORD_W-1 -: PAGE_W] == '0);

  always_comb begin
    rdData = cartData;
    if (!strobes.locked) begin
      if (inWindow) rdData = bootData;
    end else begin
      for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
        if (slotRom[s] && (slotWord[s] == rdWord)) rdData = slotData[s];
      end
    end
  end

  assign ramAddr = {slotWord[strobes.ramSel][14:0], 1'b0};
  assign ramData = slotData[strobes.ramSel];

  // R4
  slots_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.locked |=> ($stable(slotData) && $stable(slotWord) && $stable(slotRom)));
  // R10
  unlocked_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobes.locked && !$past(strobes.locked)) |-> (slotRom == '0 && slotData == '0));
endmodule

// File: rtl/cheat_patch_ctrl.sv
module cheat_patch_ctrl
  import cheat_patch_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int BOOT_AW = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic               unusedWr,
  input  logic [ADDR_W-2:0]  rdWord,
  output logic [BOOT_AW-1:0] bootAddr,
  input  logic [DATA_W-1:0]  bootData,
  input  logic [DATA_W-1:0]  cartData,
  output logic [DATA_W-1:0]  rdData,
  output logic               ramValid,
  input  logic               ramReady,
  output logic [15:0]        ramAddr,
  output logic [DATA_W-1:0]  ramData,
  output logic               busy
);
  patch_strobe_t        strobes;
  logic [NUM_SLOTS-1:0] ramMaskNext;

  cheat_patch_ctrl_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .ramMaskNext(ramMaskNext), .ramReady(ramReady), .strobes(strobes),
    .unusedWr(unusedWr), .ramValid(ramValid), .busy(busy)
  );

  cheat_patch_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_AW(BOOT_AW)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .busWdata(busWdata), .rdWord(rdWord),
    .bootAddr(bootAddr), .bootData(bootData), .cartData(cartData), .rdData(rdData),
    .ramAddr(ramAddr), .ramData(ramData), .ramMaskNext(ramMaskNext)
  );
endmodule

// File: tb/cheat_patch_ctrl_bench.sv
module cheat_patch_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busWe = 1'b0;
  logic [23:0] busAddr = '0;
  logic [15:0] busWdata = '0;
  logic        unusedWr;
  logic [22:0] rdWord = '0;
  logic [13:0] bootAddr;
  logic [15:0] bootData, cartData, rdData;
  logic        ramValid, ramReady = 1'b1, busy;
  logic [15:0] ramAddr, ramData;

  int tests = 0;
  int fails = 0;
  int ramCount = 0;
  logic [15:0] gotAddr [16];
  logic [15:0] gotData [16];
  logic [15:0] tbRegs [13];
  logic [23:0] expAddr [4];
  logic        armed = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] bootWord(input logic [13:0] a);
    return {2'b10, a} ^ 16'h0F0F;
  endfunction
  function automatic logic [15:0] cartWord(input logic [22:0] w);
    return w[15:0] ^ 16'h5A5A ^ {1'b0, w[22:16], 8'h00};
  endfunction

  assign bootData = bootWord(bootAddr);
  assign cartData = cartWord(rdWord);

  cheat_patch_ctrl u_cheat_patch_ctrl (
    .clk(clk), .rst(rst), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .unusedWr(unusedWr), .rdWord(rdWord), .bootAddr(bootAddr), .bootData(bootData),
    .cartData(cartData), .rdData(rdData), .ramValid(ramValid), .ramReady(ramReady),
    .ramAddr(ramAddr), .ramData(ramData), .busy(busy)
  );

  always @(posedge clk) begin
    if (!rst && ramValid && ramReady && ramCount < 16) begin
      gotAddr[ramCount] = ramAddr;
      gotData[ramCount] = ramData;
      ramCount = ramCount + 1;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; busWe = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    armed = 1'b0;
    for (int i = 0; i < 13; i++) tbRegs[i] = '0;
  endtask

  // byte-address write, checks unusedWr against expectation
  task automatic wrBus(input logic [23:0] a, input logic [15:0] d, input logic expUnused, input string tag);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    #1;
    check(unusedWr == expUnused, tag, unusedWr, expUnused);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic wrReg(input int idx, input logic [15:0] d);
    wrBus(24'h010000 + 24'(idx * 2), d, 1'b0, "R2 register write accepted");
    tbRegs[idx] = d;
  endtask

  // rebuild entry addresses from raw register values (R4)
  task automatic buildSlots();
    for (int k = 0; k < 4; k++) begin
      int di;
      logic [23:0] lo, hi;
      di = (k == 0) ? 0 : 3 * k + 1;
      lo = {8'h00, tbRegs[di+1]};
      hi = {8'h00, tbRegs[di+2] & 16'h7F00};
      expAddr[k] = (lo | (hi << 8)) << 1;
    end
  endtask

  function automatic logic [15:0] expRead(input logic [22:0] w);
    if (!armed) return (w[22:15] == 0) ? bootWord(w[13:0]) : cartWord(w);
    for (int k = 0; k < 4; k++) begin
      int di;
      di = (k == 0) ? 0 : 3 * k + 1;
      if (expAddr[k][23:16] < 8'h40 && expAddr[k][23:1] == w) return tbRegs[di];
    end
    return cartWord(w);
  endfunction

  task automatic readChk(input logic [23:0] byteA, input string tag);
    rdWord = byteA[23:1];
    #1;
    check(rdData == expRead(byteA[23:1]), tag, rdData, expRead(byteA[23:1]));
  endtask

  task automatic sweepLow(input string tag);
    for (int a = 0; a < 24'h004000; a += 2) readChk(24'(a), tag);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    #1;
    check(busy == 1'b0 && ramValid == 1'b0, "R1 idle during reset", {busy, ramValid}, 0);
    check(unusedWr == 1'b0, "R1 unusedWr idle", unusedWr, 0);
    doReset();
    #1;
    check(busy == 1'b0 && ramValid == 1'b0, "R1 idle after reset", {busy, ramValid}, 0);
    readChk(24'h000000, "R1 boot window after reset");

    // R5: boot window and mirror
    for (int a = 0; a < 24'h010000; a += 2 * 37) begin
      rdWord = 23'(a >> 1);
      #1;
      check(bootAddr == 14'(a >> 1), "R5 bootAddr mirror", bootAddr, 14'(a >> 1));
      readChk(24'(a), "R5 boot window read");
    end
    readChk(24'h008000, "R5 mirror 0x8000");
    readChk(24'h010000, "R5 outside window cart");
    readChk(24'h3FFFFE, "R5 outside window cart top");

    // R2: address decode
    wrBus(24'h01001A, 16'h1111, 1'b1, "R2 above window dropped");
    wrBus(24'h020000, 16'h1111, 1'b1, "R2 other page dropped");
    wrBus(24'h00FFFE, 16'h1111, 1'b1, "R2 below window dropped");

    // Scenario A: ROM, RAM, duplicate ROM, ignored
    wrReg(0, 16'hAAAA); wrReg(1, 16'h0800); wrReg(2, 16'h80AB);
    wrReg(4, 16'hBEEF); wrReg(5, 16'h891A); wrReg(6, 16'h7FC3);
    wrReg(7, 16'hCCCC); wrReg(8, 16'h0800); wrReg(9, 16'h0000);
    wrReg(10, 16'hDDDD); wrReg(11, 16'h0000); wrReg(12, 16'h2800);
    wrReg(3, 16'h1234);
    #1;
    check(busy == 1'b0, "R3 non-key value does not arm", busy, 0);
    wrReg(0, 16'hAAAA);
    readChk(24'h001000, "R3 still boot window after non-key");
    buildSlots();
    check(expAddr[1] == 24'hFF1234, "R4 formula bench self", expAddr[1], 24'hFF1234);
    ramReady = 1'b1;
    wrReg(3, 16'hFFFF);
    armed = 1'b1;
    #1;
    check(busy == 1'b1 && ramValid == 1'b1, "R8 busy after arm", busy, 1);
    check(ramAddr == 16'h1234 && ramData == 16'hBEEF, "R8 RAM request A", ramAddr, 16'h1234);
    @(negedge clk);
    #1;
    check(busy == 1'b0, "R8 busy clears", busy, 0);
    check(ramCount == 1, "R9 only one RAM write", ramCount, 1);
    wrBus(24'h010000, 16'h5555, 1'b1, "R3 locked write dropped");
    wrBus(24'h010006, 16'h0000, 1'b1, "R3 locked key write dropped");
    sweepLow("R6 R7 armed low sweep A");
    readChk(24'h001000, "R7 lowest slot wins");
    readChk(24'h500000, "R9 ignored slot no substitution");
    readChk(24'hFF1234, "R8 RAM slot no read substitution");

    // Scenario B: three RAM entries, boundary ROM word, stalls
    doReset();
    wrReg(0, 16'h1111); wrReg(1, 16'h0008); wrReg(2, 16'h7000);
    wrReg(4, 16'h2222); wrReg(5, 16'hFFFF); wrReg(6, 16'h1F00);
    wrReg(7, 16'h3333); wrReg(8, 16'h55E7); wrReg(9, 16'h7000);
    wrReg(10, 16'h4444); wrReg(11, 16'hFFFF); wrReg(12, 16'h7F00);
    buildSlots();
    ramReady = 1'b0;
    ramCount = 0;
    wrReg(3, 16'hFFFF);
    armed = 1'b1;
    begin
      logic prevStall = 1'b0;
      logic [15:0] prevA = '0;
      for (int k = 0; k < 12; k++) begin
        #1;
        if (prevStall)
          check(ramValid && ramAddr == prevA, "R8 hold while stalled", ramAddr, prevA);
        ramReady = (k % 3 == 2);
        prevStall = ramValid && !ramReady;
        prevA = ramAddr;
        @(negedge clk);
      end
    end
    #1;
    check(busy == 1'b0, "R8 busy clears after stalls", busy, 0);
    check(ramCount == 3, "R8 RAM write count", ramCount, 3);
    check(gotAddr[0] == 16'h0010 && gotData[0] == 16'h1111, "R8 order 0", gotAddr[0], 16'h0010);
    check(gotAddr[1] == 16'hABCE && gotData[1] == 16'h3333, "R8 order 1", gotAddr[1], 16'hABCE);
    check(gotAddr[2] == 16'hFFFE && gotData[2] == 16'h4444, "R8 order 2", gotAddr[2], 16'hFFFE);
    readChk(24'h3FFFFE, "R7 boundary ROM word patched");
    readChk(24'h3FFFFC, "R7 neighbour unpatched");
    readChk(24'h400000, "R9 above ROM unpatched");
    sweepLow("R6 armed low sweep B");

    // R10: reset clears registers and patches
    doReset();
    ramReady = 1'b1;
    ramCount = 0;
    #1;
    check(busy == 1'b0, "R10 busy clear", busy, 0);
    readChk(24'h3FFFFE, "R10 old patch gone");
    readChk(24'h001000, "R10 boot window restored");
    wrReg(3, 16'hFFFF);
    armed = 1'b1;
    buildSlots();
    readChk(24'h000000, "R10 zeroed entries hit word 0");
    readChk(24'h000002, "R10 word 2 from cart");
    repeat (3) @(negedge clk);
    check(ramCount == 0, "R10 no RAM writes", ramCount, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule